// File: doc/BRIEF.md
# Serial Flash Write Framing Guard

This block watches the serial bus of a flash device and decides, when chip select goes inactive, whether a write-class command should be handed to the internal write engine. It samples the serial clock, chip select and data input in its own system clock domain. It counts serial clock rising edges within each frame and captures the first eight data bits as the opcode. At the close of the frame it checks the frame length against the rules for that command type. The result is a one-cycle commit pulse or a one-cycle reject pulse, both carrying the opcode.

A frame counts only if it starts after the power-up wait has elapsed. Read-class and unrecognised opcodes never cause a decision. A frame that closes part way through a byte never commits. A status-register write commits only when it is exactly the opcode plus one data byte. Page-program frames must consist of whole bytes and must carry at least one data byte after the address.

Top module: `spiwg_write_guard`

## Requirements
- R1: While reset is held, `wr_commit`, `wr_reject` and `pwr_ready` are 0 and `wr_opcode` is 8'h00.
- R2: `pwr_ready` is 0 for the first PWRUP_CYCLES-1 clock edges after reset release and 1 from edge PWRUP_CYCLES onward. A frame whose chip-select fall is seen before `pwr_ready` is 1 produces no decision, even if it ends after that.
- R3: Opcode OP_STATUS_WR (default 8'h01) commits only when the frame holds exactly 16 serial clock rising edges. Every other length of 8 or more edges is rejected.
- R4: Opcode OP_PROG (default 8'h02) commits when the edge count is a multiple of 8 and at least (ADDR_BYTES+2)*8. Otherwise it is rejected.
- R5: The plain write opcodes in PLAIN_OPS (defaults 8'h06, 8'h04, 8'h20, 8'hD8, 8'hC7) commit when the edge count is a multiple of 8. Otherwise they are rejected.
- R6: Any other opcode (for example 8'h03 or 8'h9F) produces neither `wr_commit` nor `wr_reject`, whatever the frame length.
- R7: A frame with fewer than 8 serial clock rising edges produces no decision.
- R8: `wr_commit` and `wr_reject` are never high together. Each is high for at most one clock, and at most one decision is made per frame.
- R9: The opcode is the first 8 data bits of the frame, most significant bit first. It is presented on `wr_opcode` in the cycle of the decision pulse.
- R10: The edge counter saturates at 2**CNT_W-1. A frame of that many edges or more is rejected for every write-class opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the bus |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data toward the device |
| pwr_ready | output | 1 | High once the power-up wait is over |
| wr_commit | output | 1 | One-cycle pulse: write command accepted |
| wr_reject | output | 1 | One-cycle pulse: write command discarded |
| wr_opcode | output | 8 | Opcode of the frame just decided |

## Verification
Status-write, page-program, plain write, read and identification opcodes are each run over every frame length from 0 to 47 edges. This sweep separates byte-boundary endings from partial-byte endings. It also separates the exact-length status rule from the minimum-length program rule and from the pass-through of read opcodes. A page-program frame of 248 edges must commit and one of 256 edges must reject, which shows that the counter saturates instead of wrapping back to a byte boundary. One frame is started before the power-up wait ends and closed after it, which shows that the gate applies at the start of the frame.

// File: rtl/spiwg_pkg.sv
package spiwg_pkg;
   typedef enum logic [1:0] {
      CLS_PASS   = 2'd0,
      CLS_STATUS = 2'd1,
      CLS_PROG   = 2'd2,
      CLS_PLAIN  = 2'd3
   } cmd_cls_e;

   typedef enum logic [1:0] {
      VERD_NONE   = 2'd0,
      VERD_COMMIT = 2'd1,
      VERD_REJECT = 2'd2
   } verdict_e;
endpackage

// File: rtl/spiwg_sync.sv
module spiwg_sync #(
   parameter int          STAGES = 2,
   parameter int          W      = 1,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 1) begin : g_bad_stages
      $error("spiwg_sync: STAGES must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stg[s] <= INIT;
         else if (s == 0)
            stg[s] <= d;
         else
            stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spiwg_frame_cnt.sv
module spiwg_frame_cnt #(
   parameter int CNT_W = 12,
   parameter int OP_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_frame,
   input  logic             sck_rise,
   input  logic             frame_end,
   input  logic             sdi,
   output logic [CNT_W-1:0] bit_cnt,
   output logic [OP_W-1:0]  opcode
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] OP_LEN  = CNT_W'(OP_W);

   if (CNT_W <= $clog2(OP_W + 1)) begin : g_bad_width
      $error("spiwg_frame_cnt: CNT_W too small for the opcode");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         opcode  <= '0;
      end else if (frame_end) begin
         bit_cnt <= '0;
         opcode  <= '0;
      end else if (in_frame && sck_rise) begin
         if (bit_cnt < OP_LEN)
            opcode <= {opcode[OP_W-2:0], sdi};
         if (bit_cnt != CNT_MAX)
            bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && sck_rise && !frame_end && bit_cnt == CNT_MAX) |=> (bit_cnt == CNT_MAX));

   assert_clear_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (bit_cnt == '0));

   assert_opcode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && bit_cnt >= OP_LEN) |=> $stable(opcode));
endmodule

// File: rtl/spiwg_classify.sv
module spiwg_classify
   import spiwg_pkg::*;
#(
   parameter logic [7:0]           OP_STATUS_WR = 8'h01,
   parameter logic [7:0]           OP_PROG      = 8'h02,
   parameter int                   N_PLAIN      = 5,
   parameter logic [N_PLAIN*8-1:0] PLAIN_OPS    = {8'h06, 8'h04, 8'h20, 8'hD8, 8'hC7}
) (
   input  logic [7:0] opcode,
   output cmd_cls_e   cls
);
   logic [N_PLAIN-1:0] plain_hit;

   if (N_PLAIN < 1) begin : g_bad_plain
      $error("spiwg_classify: N_PLAIN must be at least 1");
   end

   for (genvar k = 0; k < N_PLAIN; k++) begin : g_plain
      assign plain_hit[k] = (opcode == PLAIN_OPS[k*8 +: 8]);
   end

   always_comb begin
      if (opcode == OP_STATUS_WR)
         cls = CLS_STATUS;
      else if (opcode == OP_PROG)
         cls = CLS_PROG;
      else if (|plain_hit)
         cls = CLS_PLAIN;
      else
         cls = CLS_PASS;
   end
endmodule

// File: rtl/spiwg_rules.sv
module spiwg_rules
   import spiwg_pkg::*;
#(
   parameter int CNT_W         = 12,
   parameter int STATUS_BITS   = 16,
   parameter int PROG_MIN_BITS = 40
) (
   input  cmd_cls_e         cls,
   input  logic [CNT_W-1:0] bit_cnt,
   output verdict_e         verdict
);
   localparam logic [CNT_W-1:0] OP_BITS  = CNT_W'(8);
   localparam logic [CNT_W-1:0] STAT_LEN = CNT_W'(STATUS_BITS);
   localparam logic [CNT_W-1:0] PROG_MIN = CNT_W'(PROG_MIN_BITS);

   if (PROG_MIN_BITS >= (2**CNT_W) - 1) begin : g_bad_prog
      $error("spiwg_rules: counter cannot reach the program minimum");
   end

   logic whole_bytes;
   logic length_ok;

   assign whole_bytes = (bit_cnt[2:0] == 3'd0);

   always_comb begin
      unique case (cls)
         CLS_STATUS: length_ok = (bit_cnt == STAT_LEN);
         CLS_PROG:   length_ok = whole_bytes && (bit_cnt >= PROG_MIN);
         default:    length_ok = whole_bytes;
      endcase
      if (bit_cnt < OP_BITS || cls == CLS_PASS)
         verdict = VERD_NONE;
      else if (length_ok)
         verdict = VERD_COMMIT;
      else
         verdict = VERD_REJECT;
   end
endmodule

// File: rtl/spiwg_write_guard.sv
module spiwg_write_guard
   import spiwg_pkg::*;
#(
   parameter int                   PWRUP_CYCLES = 10000,
   parameter int                   SYNC_STAGES  = 2,
   parameter int                   CNT_W        = 12,
   parameter int                   ADDR_BYTES   = 3,
   parameter logic [7:0]           OP_STATUS_WR = 8'h01,
   parameter logic [7:0]           OP_PROG      = 8'h02,
   parameter int                   N_PLAIN      = 5,
   parameter logic [N_PLAIN*8-1:0] PLAIN_OPS    = {8'h06, 8'h04, 8'h20, 8'hD8, 8'hC7}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_sdi,
   output logic       pwr_ready,
   output logic       wr_commit,
   output logic       wr_reject,
   output logic [7:0] wr_opcode
);
   localparam int PU_W          = $clog2(PWRUP_CYCLES + 1);
   localparam int PROG_MIN_BITS = (ADDR_BYTES + 2) * 8;

   if (PWRUP_CYCLES < 1) begin : g_bad_pwrup
      $error("spiwg_write_guard: PWRUP_CYCLES must be at least 1");
   end

   // synchronised pins: {cs_n, sck, sdi}, chip select idles high
   logic [2:0] pins_s;
   spiwg_sync #(.STAGES(SYNC_STAGES), .W(3), .INIT(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({spi_cs_n, spi_sck, spi_sdi}),
      .q    (pins_s)
   );

   logic cs_s, sck_s, sdi_s, cs_d, sck_d;
   assign {cs_s, sck_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   logic cs_fall, cs_rise, sck_rise, in_frame;
   assign cs_fall  = !cs_s && cs_d;
   assign cs_rise  = cs_s && !cs_d;
   assign sck_rise = sck_s && !sck_d;
   assign in_frame = !cs_s;

   // power-up wait
   logic [PU_W-1:0] pu_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pu_cnt <= '0;
      else if (pu_cnt != PU_W'(PWRUP_CYCLES))
         pu_cnt <= pu_cnt + 1'b1;
   end
   assign pwr_ready = (pu_cnt == PU_W'(PWRUP_CYCLES));

   // a frame is honoured only if it opened after power-up
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (cs_fall)
         armed <= pwr_ready;
      else if (cs_rise)
         armed <= 1'b0;
   end

   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       opcode;
   spiwg_frame_cnt #(.CNT_W(CNT_W), .OP_W(8)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_frame (in_frame),
      .sck_rise (sck_rise),
      .frame_end(cs_rise),
      .sdi      (sdi_s),
      .bit_cnt  (bit_cnt),
      .opcode   (opcode)
   );

   cmd_cls_e cls;
   spiwg_classify #(
      .OP_STATUS_WR(OP_STATUS_WR),
      .OP_PROG     (OP_PROG),
      .N_PLAIN     (N_PLAIN),
      .PLAIN_OPS   (PLAIN_OPS)
   ) u_cls (
      .opcode(opcode),
      .cls   (cls)
   );

   verdict_e verdict;
   spiwg_rules #(
      .CNT_W        (CNT_W),
      .STATUS_BITS  (16),
      .PROG_MIN_BITS(PROG_MIN_BITS)
   ) u_rules (
      .cls    (cls),
      .bit_cnt(bit_cnt),
      .verdict(verdict)
   );

   logic decide;
   assign decide = cs_rise && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_commit <= 1'b0;
         wr_reject <= 1'b0;
         wr_opcode <= '0;
      end else begin
         wr_commit <= decide && (verdict == VERD_COMMIT);
         wr_reject <= decide && (verdict == VERD_REJECT);
         if (decide && verdict != VERD_NONE)
            wr_opcode <= opcode;
      end
   end

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_commit && wr_reject));

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit || wr_reject) |=> !(wr_commit || wr_reject));

   assert_ready_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ready |=> pwr_ready);

   assert_gated_by_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit || wr_reject) |-> pwr_ready);
endmodule

// File: tb/tb_spiwg_write_guard.sv
module tb_spiwg_write_guard;
   localparam int CLK_PERIOD = 10;
   localparam int PU         = 50;
   localparam int CW         = 8;
   localparam int ADDR_B     = 3;
   localparam int HALF       = 4;
   localparam int SAT        = (1 << CW) - 1;
   localparam int PROG_MIN   = (ADDR_B + 2) * 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
   logic pwr_ready, wr_commit, wr_reject;
   logic [7:0] wr_opcode;

   always #(CLK_PERIOD/2) clk = ~clk;

   spiwg_write_guard #(
      .PWRUP_CYCLES(PU), .SYNC_STAGES(2), .CNT_W(CW), .ADDR_BYTES(ADDR_B)
   ) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
      .pwr_ready(pwr_ready), .wr_commit(wr_commit), .wr_reject(wr_reject),
      .wr_opcode(wr_opcode)
   );

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // result: 0 none, 1 commit, 2 reject, 3 malformed pulses
   task automatic frame(input logic [7:0] op, input int nbits,
                        output int res, output logic [7:0] got);
      int c, r;
      got = 8'h00;
      @(negedge clk) cs_n = 1'b0;
      idle(HALF);
      for (int i = 0; i < nbits; i++) begin
         sdi = (i < 8) ? op[7-i] : ((i % 3) == 1);
         sck = 1'b0; idle(HALF);
         sck = 1'b1; idle(HALF);
      end
      sck = 1'b0; idle(HALF);
      cs_n = 1'b1; sdi = 1'b0;
      c = 0; r = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (wr_commit) begin c++; got = wr_opcode; end
         if (wr_reject) begin r++; got = wr_opcode; end
      end
      if (c == 0 && r == 0)      res = 0;
      else if (c == 1 && r == 0) res = 1;
      else if (c == 0 && r == 1) res = 2;
      else                       res = 3;
   endtask

   function automatic int model(input logic [7:0] op, input int n);
      int ns;
      bit whole;
      ns = (n > SAT) ? SAT : n;
      whole = (ns % 8) == 0;
      if (n < 8) return 0;
      case (op)
         8'h01: return (ns == 16) ? 1 : 2;
         8'h02: return (whole && ns >= PROG_MIN) ? 1 : 2;
         8'h06, 8'h04, 8'h20, 8'hD8, 8'hC7: return whole ? 1 : 2;
         default: return 0;
      endcase
   endfunction

   function automatic string tag(input logic [7:0] op, input int n);
      if (n > SAT) return "R10";
      if (n < 8) return "R7";
      case (op)
         8'h01: return "R3";
         8'h02: return "R4";
         8'h06, 8'h04, 8'h20, 8'hD8, 8'hC7: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic run_one(input logic [7:0] op, input int n);
      int res, exp;
      logic [7:0] got;
      frame(op, n, res, got);
      exp = model(op, n);
      check(res == exp, tag(op, n), $sformatf("op %02h len %0d verdict", op, n), res, exp);
      check(res != 3, "R8", "pulse shape", res, exp);
      if (res == 1 || res == 2)
         check(got == op, "R9", "opcode on decision", int'(got), int'(op));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] ops [6];
      int res;
      logic [7:0] got;
      ops = '{8'h01, 8'h02, 8'h06, 8'hD8, 8'h03, 8'h9F};

      // R1: reset state
      idle(3);
      check(wr_commit == 0 && wr_reject == 0, "R1", "pulses in reset", int'(wr_commit | wr_reject), 0);
      check(pwr_ready == 0, "R1", "ready in reset", int'(pwr_ready), 0);
      check(wr_opcode == 8'h00, "R1", "opcode in reset", int'(wr_opcode), 0);

      // R2: power-up wait length
      @(negedge clk) rst_n = 1'b1;
      idle(PU - 1);
      check(pwr_ready == 0, "R2", "ready one edge early", int'(pwr_ready), 0);
      idle(1);
      check(pwr_ready == 1, "R2", "ready at wait end", int'(pwr_ready), 1);

      // sweep: every opcode class across every length 0..47
      foreach (ops[j])
         for (int n = 0; n < 48; n++)
            run_one(ops[j], n);

      // R4/R10: long program frames, below and beyond saturation
      run_one(8'h02, 248);
      run_one(8'h02, 256);
      run_one(8'h06, 256);

      // R2: frame opened before power-up is ignored
      @(negedge clk) rst_n = 1'b0;
      idle(2);
      @(negedge clk) rst_n = 1'b1;
      frame(8'h06, 64, res, got);
      check(res == 0, "R2", "frame opened before ready", res, 0);
      check(pwr_ready == 1, "R2", "ready after early frame", int'(pwr_ready), 1);
      run_one(8'h06, 8);

      done = 1;
      summary();
      $finish;
   end
endmodule